// File: doc/BRIEF.md
# Byte-Lane Register and Operand Store

This block stores the architectural operand state of a small 16-bit datapath: eight 16-bit registers and sixteen bytes of data memory. A single operand read port and a single writeback port both use the same addressing: an operand is a register, a memory byte or word whose address sits in a register, or a memory byte or word at an immediate 20-bit address. A size select chooses between 8-bit and 16-bit access.

Register reads and memory reads are combinational. Writes take effect at the next rising clock edge. Only the low byte of the first four registers can be reached as an 8-bit operand. A register-indirect address is the full 16-bit register value, zero-extended to 20 bits with no segment base added. A 16-bit memory operand occupies two adjacent bytes in little-endian order. An access that names something outside the implemented storage raises an error flag and changes nothing. The reset is asynchronous and active-low. Its release is synchronised inside the block.

Top module: `lane_store`

## Requirements
- R1: Register index 0..7 selects AX, BX, CX, DX, DS, DI, BP, SP. A 16-bit register write (kind 0, wide 1) is visible on the 16-bit read of that index from the cycle after the write edge. Other registers are unchanged.
- R2: For indexes 0..3 with wide 0, a read returns the low byte in rd_data[7:0] with bits 15:8 zero. A write replaces only bits 7:0 and keeps bits 15:8.
- R3: An 8-bit register access to indexes 4..7 sets the error flag. The read data is zero, and the write changes no register.
- R4: Memory holds 16 bytes at addresses 0x00000..0x0000F. An 8-bit memory write changes only the addressed byte.
- R5: A 16-bit memory access uses the byte at the effective address as bits 7:0 and the byte at address+1 as bits 15:8.
- R6: Kind 1 forms the address as {4'b0, register[idx]}. Kind 2 uses the 20-bit immediate unchanged, and all 20 bits take part in the range check.
- R7: An access is in range when the address is at most 15 for a byte, or at most 14 for a word. Out-of-range memory access or kind 3 sets the error flag, reads zero, and a write then changes no storage.
- R8: While reset is asserted, and after it is released, every register and memory byte reads zero. Asserting reset mid-run clears all state.
- R9: A read in the same cycle as a write to the same operand returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_kind | input | 2 | Read operand kind: 0 register, 1 memory at register, 2 memory at immediate, 3 invalid |
| rd_idx | input | 3 | Register index, or base register for kind 1 |
| rd_wide | input | 1 | 1 selects a 16-bit operand, 0 an 8-bit operand |
| rd_addr | input | 20 | Immediate memory address for kind 2 |
| rd_data | output | 16 | Operand value, zero-extended for byte reads |
| rd_err | output | 1 | Read operand is illegal or out of range |
| wr_en | input | 1 | Writeback strobe |
| wr_kind | input | 2 | Writeback operand kind, same encoding as rd_kind |
| wr_idx | input | 3 | Register index, or base register for kind 1 |
| wr_wide | input | 1 | 1 selects a 16-bit writeback, 0 an 8-bit writeback |
| wr_addr | input | 20 | Immediate memory address for kind 2 |
| wr_data | input | 16 | Writeback value; bits 7:0 used for byte writes |
| wr_err | output | 1 | Writeback is illegal or out of range and is dropped |

## Verification
A corrupted register or memory byte shows on rd_data as soon as that operand is addressed, with no pipeline delay, because reads are combinational. Each write is therefore followed at once by reads of the target and of its neighbours. A byte write that disturbs a high byte, a word write with swapped lanes, or a dropped write that still lands all show up on the next read of the adjacent byte or of the full word. An address path that truncates the upper bits is exposed within one cycle, because an out-of-range address returns data instead of the error flag.

// File: rtl/lane_pkg.sv
`timescale 1ns/1ps
package lane_pkg;
  parameter int unsigned NREG      = 8;
  parameter int unsigned WORD_W    = 16;
  parameter int unsigned BYTE_W    = 8;
  parameter int unsigned MEM_BYTES = 16;
  parameter int unsigned ADDR_W    = 20;
  parameter int unsigned BYTE_REGS = 4;

  typedef enum logic [1:0] {
    SRC_REG     = 2'd0,
    SRC_MEM_REG = 2'd1,
    SRC_MEM_IMM = 2'd2,
    SRC_BAD     = 2'd3
  } src_e;
endpackage

// File: rtl/lane_ea.sv
`timescale 1ns/1ps
module lane_ea import lane_pkg::*; #(
  parameter int unsigned WW = WORD_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned MB = MEM_BYTES
) (
  input  src_e                   kind_i,
  input  logic [WW-1:0]          base_i,
  input  logic [AW-1:0]          imm_i,
  input  logic                   wide_i,
  output logic [$clog2(MB)-1:0]  ma_o,
  output logic                   ok_o
);
  localparam int unsigned MA = $clog2(MB);

  logic [AW-1:0] ea;

  always_comb begin
    if (kind_i == SRC_MEM_IMM) ea = imm_i;
    else                       ea = {{(AW-WW){1'b0}}, base_i};
    if (wide_i) ok_o = (ea < AW'(MB - 1));
    else        ok_o = (ea < AW'(MB));
    ma_o = ea[MA-1:0];
  end
endmodule

// File: rtl/lane_regfile.sv
`timescale 1ns/1ps
module lane_regfile import lane_pkg::*; #(
  parameter int unsigned NR = NREG,
  parameter int unsigned WW = WORD_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic                      wide_i,
  input  logic [$clog2(NR)-1:0]     idx_i,
  input  logic [WW-1:0]             data_i,
  output logic [NR-1:0][WW-1:0]     regs_o
);
  localparam int unsigned IW = $clog2(NR);

  logic [WW-1:0] q [NR];
  logic [WW-1:0] d [NR];
  logic [NR-1:0] en;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      en[i] = we_i && (idx_i == IW'(i));
      d[i]  = wide_i ? data_i : {q[i][WW-1:BW], data_i[BW-1:0]};
    end
  end

  for (genvar g = 0; g < NR; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= '0;
      else if (en[g]) q[g] <= d[g];
    end
    assign regs_o[g] = q[g];
  end

  AST_BYTE_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !wide_i) |=> (q[$past(idx_i)][WW-1:BW] == $past(q[idx_i][WW-1:BW])))
    else $error("byte write altered high byte"); // R2
endmodule

// File: rtl/lane_dmem.sv
`timescale 1ns/1ps
module lane_dmem import lane_pkg::*; #(
  parameter int unsigned MB = MEM_BYTES,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned WW = WORD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic                      wide_i,
  input  logic [$clog2(MB)-1:0]     addr_i,
  input  logic [WW-1:0]             data_i,
  output logic [MB-1:0][BW-1:0]     mem_o
);
  localparam int unsigned MA = $clog2(MB);

  logic [BW-1:0] q [MB];
  logic [BW-1:0] d [MB];
  logic [MB-1:0] en;
  logic [MA-1:0] hi_addr;

  assign hi_addr = addr_i + MA'(1);

  always_comb begin
    for (int i = 0; i < MB; i++) begin
      en[i] = we_i && ((addr_i == MA'(i)) || (wide_i && (hi_addr == MA'(i))));
      d[i]  = (wide_i && (hi_addr == MA'(i))) ? data_i[2*BW-1:BW] : data_i[BW-1:0];
    end
  end

  for (genvar g = 0; g < MB; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= '0;
      else if (en[g]) q[g] <= d[g];
    end
    assign mem_o[g] = q[g];
  end

  AST_WORD_LITTLE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wide_i) |=> ((q[$past(addr_i)] == $past(data_i[BW-1:0])) &&
                          (q[$past(hi_addr)] == $past(data_i[2*BW-1:BW]))))
    else $error("word write lane order wrong"); // R5

  AST_BYTE_NEIGHBOUR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !wide_i && (addr_i != MA'(MB - 1))) |=> (q[$past(hi_addr)] == $past(q[hi_addr])))
    else $error("byte write touched next byte"); // R4
endmodule

// File: rtl/lane_store.sv
`timescale 1ns/1ps
module lane_store import lane_pkg::*; #(
  parameter int unsigned NR = NREG,
  parameter int unsigned WW = WORD_W,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned MB = MEM_BYTES,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NB = BYTE_REGS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            rd_kind,
  input  logic [$clog2(NR)-1:0] rd_idx,
  input  logic                  rd_wide,
  input  logic [AW-1:0]         rd_addr,
  output logic [WW-1:0]         rd_data,
  output logic                  rd_err,
  input  logic                  wr_en,
  input  logic [1:0]            wr_kind,
  input  logic [$clog2(NR)-1:0] wr_idx,
  input  logic                  wr_wide,
  input  logic [AW-1:0]         wr_addr,
  input  logic [WW-1:0]         wr_data,
  output logic                  wr_err
);
  localparam int unsigned MA = $clog2(MB);

  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  logic [NR-1:0][WW-1:0] regs;
  logic [MB-1:0][BW-1:0] mem;
  src_e                  rd_src, wr_src;
  logic [MA-1:0]         rd_ma, wr_ma, rd_ma_hi;
  logic                  rd_ok, wr_ok;
  logic                  rf_we, dm_we;

  assign rd_src   = src_e'(rd_kind);
  assign wr_src   = src_e'(wr_kind);
  assign rd_ma_hi = rd_ma + MA'(1);

  lane_ea #(.WW(WW), .AW(AW), .MB(MB)) u_rd_ea (
    .kind_i(rd_src), .base_i(regs[rd_idx]), .imm_i(rd_addr),
    .wide_i(rd_wide), .ma_o(rd_ma), .ok_o(rd_ok)
  );

  lane_ea #(.WW(WW), .AW(AW), .MB(MB)) u_wr_ea (
    .kind_i(wr_src), .base_i(regs[wr_idx]), .imm_i(wr_addr),
    .wide_i(wr_wide), .ma_o(wr_ma), .ok_o(wr_ok)
  );

  lane_regfile #(.NR(NR), .WW(WW), .BW(BW)) u_rf (
    .clk(clk), .rst_n(rst_ni), .we_i(rf_we), .wide_i(wr_wide),
    .idx_i(wr_idx), .data_i(wr_data), .regs_o(regs)
  );

  lane_dmem #(.MB(MB), .BW(BW), .WW(WW)) u_dm (
    .clk(clk), .rst_n(rst_ni), .we_i(dm_we), .wide_i(wr_wide),
    .addr_i(wr_ma), .data_i(wr_data), .mem_o(mem)
  );

  // operand read
  always_comb begin
    rd_data = '0;
    rd_err  = 1'b0;
    case (rd_src)
      SRC_REG: begin
        if (rd_wide)                  rd_data = regs[rd_idx];
        else if (int'(rd_idx) < NB)   rd_data = WW'(regs[rd_idx][BW-1:0]);
        else                          rd_err  = 1'b1;
      end
      SRC_MEM_REG, SRC_MEM_IMM: begin
        if (!rd_ok) rd_err = 1'b1;
        else begin
          rd_data[BW-1:0] = mem[rd_ma];
          if (rd_wide) rd_data[2*BW-1:BW] = mem[rd_ma_hi];
        end
      end
      default: rd_err = 1'b1;
    endcase
  end

  // writeback steering
  always_comb begin
    rf_we  = 1'b0;
    dm_we  = 1'b0;
    wr_err = 1'b0;
    if (wr_en) begin
      case (wr_src)
        SRC_REG: begin
          if (wr_wide || (int'(wr_idx) < NB)) rf_we  = 1'b1;
          else                                wr_err = 1'b1;
        end
        SRC_MEM_REG, SRC_MEM_IMM: begin
          if (wr_ok) dm_we  = 1'b1;
          else       wr_err = 1'b1;
        end
        default: wr_err = 1'b1;
      endcase
    end
  end

  AST_DROPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_err |=> ((regs == $past(regs)) && (mem == $past(mem))))
    else $error("rejected write changed storage"); // R7
endmodule

// File: tb/sim_lane_store.sv
`timescale 1ns/1ps
module sim_lane_store;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  rd_kind, wr_kind;
  logic [2:0]  rd_idx, wr_idx;
  logic        rd_wide, wr_wide, wr_en;
  logic [19:0] rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;
  logic        rd_err, wr_err;

  always #2.5 clk = ~clk;

  lane_store u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_wide(rd_wide), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_err(rd_err),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_wide(wr_wide),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_err(wr_err)
  );

  typedef struct {
    string       tag;
    bit          on_wr;
    logic [15:0] exp;
    bit          exp_err;
  } exp_t;

  exp_t sbq[$];
  exp_t it;
  int   checks = 0;
  int   fails  = 0;

  // monitor: compare each pending expectation away from the rising edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      checks++;
      if (it.on_wr) begin
        if (wr_err !== it.exp_err) begin
          fails++;
          $display("FAIL %s: wr_err=%0b expected %0b", it.tag, wr_err, it.exp_err);
        end
      end else if (rd_data !== it.exp || rd_err !== it.exp_err) begin
        fails++;
        $display("FAIL %s: data=%h err=%0b expected data=%h err=%0b",
                 it.tag, rd_data, rd_err, it.exp, it.exp_err);
      end
    end
  end

  task automatic rd(input logic [1:0] k, input logic [2:0] i, input logic w,
                    input logic [19:0] a, input logic [15:0] e, input bit ee,
                    input string t);
    @(posedge clk); #1;
    wr_en = 1'b0;
    rd_kind = k; rd_idx = i; rd_wide = w; rd_addr = a;
    sbq.push_back('{t, 1'b0, e, ee});
  endtask

  task automatic wr(input logic [1:0] k, input logic [2:0] i, input logic w,
                    input logic [19:0] a, input logic [15:0] d, input bit ee,
                    input string t);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_kind = k; wr_idx = i; wr_wide = w; wr_addr = a; wr_data = d;
    sbq.push_back('{t, 1'b1, 16'h0, ee});
  endtask

  task automatic rw_same(input logic [15:0] d, input logic [15:0] old_v, input string t);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_kind = 2'd0; wr_idx = 3'd0; wr_wide = 1'b1; wr_data = d;
    rd_kind = 2'd0; rd_idx = 3'd0; rd_wide = 1'b1;
    sbq.push_back('{t, 1'b0, old_v, 1'b0});
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0;
    rd_kind = '0; rd_idx = '0; rd_wide = 1'b1; rd_addr = '0;
    wr_kind = '0; wr_idx = '0; wr_wide = 1'b1; wr_addr = '0; wr_data = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R8 reset state
    rd(2'd0, 3'd0, 1'b1, 20'h0, 16'h0000, 1'b0, "R8 AX after reset");
    rd(2'd0, 3'd7, 1'b1, 20'h0, 16'h0000, 1'b0, "R8 SP after reset");
    rd(2'd2, 3'd0, 1'b1, 20'h0, 16'h0000, 1'b0, "R8 mem 0 after reset");
    rd(2'd2, 3'd0, 1'b1, 20'hE, 16'h0000, 1'b0, "R8 mem E after reset");

    // R1 word register access
    wr(2'd0, 3'd0, 1'b1, 20'h0, 16'h1234, 1'b0, "R1 write AX");
    rd(2'd0, 3'd0, 1'b1, 20'h0, 16'h1234, 1'b0, "R1 read AX");
    wr(2'd0, 3'd7, 1'b1, 20'h0, 16'hBEEF, 1'b0, "R1 write SP");
    rd(2'd0, 3'd7, 1'b1, 20'h0, 16'hBEEF, 1'b0, "R1 read SP");
    rd(2'd0, 3'd1, 1'b1, 20'h0, 16'h0000, 1'b0, "R1 BX untouched");

    // R2 low byte lanes
    wr(2'd0, 3'd2, 1'b1, 20'h0, 16'hA5A5, 1'b0, "R2 write CX");
    wr(2'd0, 3'd2, 1'b0, 20'h0, 16'hFF3C, 1'b0, "R2 write CL");
    rd(2'd0, 3'd2, 1'b1, 20'h0, 16'hA53C, 1'b0, "R2 CX high kept");
    rd(2'd0, 3'd2, 1'b0, 20'h0, 16'h003C, 1'b0, "R2 CL zero extended");

    // R3 byte access to upper registers
    wr(2'd0, 3'd5, 1'b0, 20'h0, 16'h0042, 1'b1, "R3 byte write DI rejected");
    rd(2'd0, 3'd5, 1'b1, 20'h0, 16'h0000, 1'b0, "R3 DI unchanged");
    rd(2'd0, 3'd4, 1'b0, 20'h0, 16'h0000, 1'b1, "R3 byte read DS rejected");

    // R5 little-endian words
    wr(2'd2, 3'd0, 1'b1, 20'h4, 16'hCAFE, 1'b0, "R5 word write at 4");
    rd(2'd2, 3'd0, 1'b0, 20'h4, 16'h00FE, 1'b0, "R5 low byte at 4");
    rd(2'd2, 3'd0, 1'b0, 20'h5, 16'h00CA, 1'b0, "R5 high byte at 5");
    rd(2'd2, 3'd0, 1'b1, 20'h4, 16'hCAFE, 1'b0, "R5 word read at 4");

    // R4 byte memory write leaves neighbour
    wr(2'd2, 3'd0, 1'b0, 20'h6, 16'h1177, 1'b0, "R4 byte write at 6");
    rd(2'd2, 3'd0, 1'b1, 20'h6, 16'h0077, 1'b0, "R4 byte 7 untouched");

    // R6 register-indirect and immediate addressing
    wr(2'd0, 3'd1, 1'b1, 20'h0, 16'h000A, 1'b0, "R6 set BX");
    wr(2'd1, 3'd1, 1'b1, 20'h0, 16'h5A69, 1'b0, "R6 word write via BX");
    rd(2'd2, 3'd0, 1'b1, 20'hA, 16'h5A69, 1'b0, "R6 word at A");
    rd(2'd1, 3'd1, 1'b0, 20'h0, 16'h0069, 1'b0, "R6 byte via BX");
    wr(2'd0, 3'd3, 1'b1, 20'h0, 16'hFFF0, 1'b0, "R6 set DX");
    rd(2'd1, 3'd3, 1'b0, 20'h0, 16'h0000, 1'b1, "R6 DX indirect out of range");
    rd(2'd2, 3'd0, 1'b0, 20'h10004, 16'h0000, 1'b1, "R6 upper immediate bits");

    // R7 range edges
    rd(2'd2, 3'd0, 1'b1, 20'hF, 16'h0000, 1'b1, "R7 word at F rejected");
    rd(2'd2, 3'd0, 1'b0, 20'hF, 16'h0000, 1'b0, "R7 byte at F allowed");
    wr(2'd2, 3'd0, 1'b0, 20'hF, 16'h0099, 1'b0, "R7 byte write at F");
    rd(2'd2, 3'd0, 1'b0, 20'hF, 16'h0099, 1'b0, "R7 byte F readback");
    wr(2'd2, 3'd0, 1'b1, 20'hF, 16'h1234, 1'b1, "R7 word write at F rejected");
    rd(2'd2, 3'd0, 1'b0, 20'hF, 16'h0099, 1'b0, "R7 byte F kept");
    rd(2'd2, 3'd0, 1'b0, 20'h0, 16'h0000, 1'b0, "R7 no wrap to 0");
    wr(2'd3, 3'd0, 1'b1, 20'h0, 16'h7777, 1'b1, "R7 kind 3 write rejected");
    rd(2'd0, 3'd0, 1'b1, 20'h0, 16'h1234, 1'b0, "R7 AX after kind 3");

    // R9 read during write
    rw_same(16'h5555, 16'h1234, "R9 same-cycle read old");
    rd(2'd0, 3'd0, 1'b1, 20'h0, 16'h5555, 1'b0, "R9 read new");

    // R8 reset mid-run
    @(posedge clk);
    do_reset();
    rd(2'd0, 3'd0, 1'b1, 20'h0, 16'h0000, 1'b0, "R8 AX cleared");
    rd(2'd2, 3'd0, 1'b1, 20'h4, 16'h0000, 1'b0, "R8 mem 4 cleared");
    rd(2'd0, 3'd7, 1'b1, 20'h0, 16'h0000, 1'b0, "R8 SP cleared");

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule